// File: doc/BRIEF.md
# SPI Slave Boot Download Receiver

This block lets an external SPI master download a program image into on-chip word memory during boot. It acts as an SPI slave in mode 0 (clock idles low, data captured on the rising edge, 8-bit frames, most significant bit first). The block oversamples the SPI clock, select and data lines with its own system clock. It runs a fixed byte-slot handshake: an opening sequence, a payload length in 32-bit words, an XOR checksum and a transfer-mode byte. It answers with acknowledge (0x02) or reject (0x20) bytes in fixed response slots.

Accepted payload bytes are packed little-endian into 32-bit words. Each word goes out through a one-cycle write port at consecutive word addresses starting from 0. After two trailing slots the block compares the running checksum, reports the result, and raises an output that asks the pad ring to turn its pins into pulled-down inputs. Only the 8-bit transfer mode is accepted. A session ends early if select is released, or if any check fails, in which case the block rejects it and falls silent until select is asserted again.

Top module: `spi_boot_rx`

## Requirements
- R1: SPI mode 0 with 8-bit frames, MSB first. The block shifts MISO on falling edges, so bit 7 of each response byte is present before that byte's first rising edge. Every slot without a response below returns 0x00, and MISO is low while select is high.
- R2: Slots 0, 1 and 2 must carry 0x70, 0x50 and 0x00. Slot 3 returns 0x02 if all three matched, otherwise 0x20; after a 0x20 the session is muted: no writes, no completion, 0x00 on MISO until the next select assertion.
- R3: Slots 3 and 4 hold the length in 32-bit words, low byte first, and slot 5 holds the expected checksum. Slot 6 returns 0x02 if the length is at most 2**ADDR_W words; otherwise it returns 0x20 and the session is muted.
- R4: Slot 6 holds the mode (0x00 8-bit, 0x01 16-bit, 0x02 32-bit, 0x03 reserved). Slot 8 returns 0x02 for 0x00 and 0x20 for any other value, which mutes the session.
- R5: With length L, the payload occupies slots 8 to 8+4L-1. Byte k goes to bits [8*(k%4)+7 : 8*(k%4)] of word k/4. Each complete word is written with a single-cycle wr_en pulse at wr_addr = k/4, starting at 0.
- R6: The checksum is the XOR of all payload bytes, seeded with 0xFF. Slot 4L+8 returns 0x00 (except when L=0, where slot 8 carries the R4 answer). Slot 4L+9 returns 0x02 if the checksum equals the slot-5 byte, otherwise 0x20.
- R7: When slot 4L+9 completes, rel_pads goes high and sum_ok shows whether the checksums matched. Both stay unchanged, and later bytes cause no writes, until the next select assertion, which clears them.
- R8: Releasing select before slot 4L+9 completes aborts the session. rel_pads stays low, no further words are written, and the next session runs normally.
- R9: After reset, spi_miso, wr_en, rel_pads and sum_ok are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI clock from the master |
| spi_cs_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Data from master |
| spi_miso | output | 1 | Response data to master |
| wr_en | output | 1 | One-cycle word write strobe |
| wr_addr | output | ADDR_W | Word address of the write |
| wr_data | output | 32 | Packed little-endian word |
| rel_pads | output | 1 | Session complete; request pads become pulled-down inputs |
| sum_ok | output | 1 | Checksum of the completed session matched |

## Verification
The bench builds the block with ADDR_W = 4, so the memory holds 16 words. This makes both the largest accepted image (16 words) and the first rejected length (17 words) short enough to send in full. The SPI half period is six system clocks, which exercises the oversampling path with little margin above the synchronizer latency. Random payloads, modes and checksum corruptions are mixed with directed cases: a zero-length image, a wrong opening byte, each rejected mode, and an abort in the middle of a word.

// File: rtl/spi_boot_rx.sv
module spi_boot_rx #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              rel_pads,
  output logic              sum_ok
);
  localparam logic [7:0] ACK  = 8'h02;
  localparam logic [7:0] NACK = 8'h20;
  localparam int SLOT_W = 19;
  localparam logic [16:0] MAX_WORDS = 17'(1) << ADDR_W;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_MUTE} st_t;
  st_t st;

  logic [2:0] sck_q, cs_q;
  logic [1:0] mo_q;
  logic [6:0] rx_sh;
  logic [2:0] bit_cnt;
  logic [7:0] tx;
  logic [SLOT_W-1:0] slot;
  logic [15:0] len;
  logic [7:0] chk_exp, run;
  logic [23:0] wbuf;
  logic pre_bad, mode_bad;

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire cs_fall  = ~cs_q[1] & cs_q[2];
  wire cs_rise  = cs_q[1] & ~cs_q[2];
  wire [7:0] rx_byte = {rx_sh, mo_q[1]};
  wire [SLOT_W-1:0] pidx = slot - SLOT_W'(8);
  wire [SLOT_W-1:0] nbytes = {1'b0, len, 2'b00};
  wire past_hdr = slot >= SLOT_W'(8);
  wire in_pay = past_hdr && (pidx < nbytes);
  wire at_t1  = past_hdr && (pidx == nbytes);
  wire at_t2  = past_hdr && (pidx == nbytes + SLOT_W'(1));
  wire match  = run == chk_exp;

  assign spi_miso = (st != S_IDLE) & tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      mo_q  <= '0;
    end else begin
      sck_q <= {sck_q[1:0], spi_sclk};
      cs_q  <= {cs_q[1:0], spi_cs_n};
      mo_q  <= {mo_q[0], spi_mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rx_sh <= '0;
      bit_cnt <= '0;
      tx <= '0;
      slot <= '0;
      len <= '0;
      chk_exp <= '0;
      run <= 8'hFF;
      wbuf <= '0;
      pre_bad <= 1'b0;
      mode_bad <= 1'b0;
      wr_en <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      rel_pads <= 1'b0;
      sum_ok <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (cs_fall) begin
        st <= S_RUN;
        slot <= '0;
        bit_cnt <= '0;
        tx <= '0;
        run <= 8'hFF;
        pre_bad <= 1'b0;
        rel_pads <= 1'b0;
        sum_ok <= 1'b0;
      end else if (cs_rise) begin
        st <= S_IDLE;
        tx <= '0;
      end else if (st != S_IDLE) begin
        if (sck_fall && bit_cnt != 3'd0) tx <= {tx[6:0], 1'b0};
        if (sck_rise) begin
          rx_sh <= rx_byte[6:0];
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            slot <= slot + SLOT_W'(1);
            tx <= 8'h00;
            if (st == S_RUN) begin
              case (slot)
                SLOT_W'(0): pre_bad <= rx_byte != 8'h70;
                SLOT_W'(1): pre_bad <= pre_bad | (rx_byte != 8'h50);
                SLOT_W'(2): begin
                  if (pre_bad || rx_byte != 8'h00) begin
                    tx <= NACK;
                    st <= S_MUTE;
                  end else tx <= ACK;
                end
                SLOT_W'(3): len[7:0] <= rx_byte;
                SLOT_W'(4): len[15:8] <= rx_byte;
                SLOT_W'(5): begin
                  chk_exp <= rx_byte;
                  if ({1'b0, len} > MAX_WORDS) begin
                    tx <= NACK;
                    st <= S_MUTE;
                  end else tx <= ACK;
                end
                SLOT_W'(6): mode_bad <= rx_byte != 8'h00;
                SLOT_W'(7): begin
                  if (mode_bad) begin
                    tx <= NACK;
                    st <= S_MUTE;
                  end else tx <= ACK;
                end
                default: begin
                  if (in_pay) begin
                    run <= run ^ rx_byte;
                    case (pidx[1:0])
                      2'd0: wbuf[7:0]   <= rx_byte;
                      2'd1: wbuf[15:8]  <= rx_byte;
                      2'd2: wbuf[23:16] <= rx_byte;
                      default: begin
                        wr_en   <= 1'b1;
                        wr_addr <= pidx[ADDR_W+1:2];
                        wr_data <= {rx_byte, wbuf};
                      end
                    endcase
                  end else if (at_t1) begin
                    tx <= match ? ACK : NACK;
                  end else if (at_t2) begin
                    rel_pads <= 1'b1;
                    sum_ok <= match;
                    st <= S_MUTE;
                  end
                end
              endcase
            end
          end
        end
      end
    end
  end
endmodule

module spi_boot_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] st,
  input logic       cs_fall,
  input logic       cs_rise,
  input logic       wr_en,
  input logic       rel_pads,
  input logic       sum_ok
);
  localparam logic [1:0] RUN_C = 2'd1;

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  a_r5_write_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(st) == RUN_C);
  a_r7_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pads && !cs_fall |=> rel_pads);
  a_r7_ok_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    sum_ok |-> rel_pads);
  a_r7_no_write_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pads |-> !wr_en);
  a_r7_done_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_pads) |-> $past(st) == RUN_C);
  a_r8_abort_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && !rel_pads |=> !rel_pads);
endmodule

bind spi_boot_rx spi_boot_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .cs_fall(cs_fall), .cs_rise(cs_rise),
  .wr_en(wr_en), .rel_pads(rel_pads), .sum_ok(sum_ok)
);

// File: tb/test_spi_boot_rx.sv
module test_spi_boot_rx;
  localparam int AW = 4;
  localparam int H = 6;
  localparam logic [7:0] ACK = 8'h02;
  localparam logic [7:0] NACK = 8'h20;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, wr_en, rel_pads, sum_ok;
  logic [AW-1:0] wr_addr;
  logic [31:0] wr_data;

  always #5 clk = ~clk;

  spi_boot_rx #(.ADDR_W(AW)) i_spi_boot_rx (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rel_pads(rel_pads), .sum_ok(sum_ok)
  );

  int checks = 0, errors = 0, wcount = 0;
  logic [31:0] bmem [0:15];
  logic [7:0] pl [0:127];
  logic [7:0] txs [0:127];
  logic [7:0] exps [0:127];
  string rq [0:127];

  always @(negedge clk) if (wr_en) begin
    wcount = wcount + 1;
    bmem[wr_addr] = wr_data;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      mosi = t[i];
      waitc(H);
      r[i] = miso;
      sclk = 1'b1;
      waitc(H);
      sclk = 1'b0;
    end
  endtask

  task automatic session(input int nw, input logic [7:0] p1, input logic [7:0] mode,
                         input bit bad_sum, input int stop_at, input int extra);
    int n, total, len_sent, exp_w;
    logic [7:0] sum, r;
    logic [15:0] l16;
    bit ok_pre, ok_len, ok_mode, all_ok, full;
    n = nw * 4;
    l16 = 16'(nw);
    sum = 8'hFF;
    for (int i = 0; i < n; i++) begin
      pl[i] = 8'($urandom);
      sum = sum ^ pl[i];
    end
    ok_pre = p1 == 8'h50;
    ok_len = nw <= 16;
    ok_mode = mode == 8'h00;
    all_ok = ok_pre && ok_len && ok_mode;
    total = 8 + n + 2 + extra;
    for (int i = 0; i < total; i++) begin
      txs[i] = 8'h00;
      exps[i] = 8'h00;
      rq[i] = "R1";
    end
    txs[0] = 8'h70; txs[1] = p1; txs[2] = 8'h00;
    txs[3] = l16[7:0]; txs[4] = l16[15:8];
    txs[5] = bad_sum ? ~sum : sum;
    txs[6] = mode;
    for (int i = 0; i < n; i++) txs[8 + i] = pl[i];
    exps[3] = ok_pre ? ACK : NACK; rq[3] = "R2";
    if (ok_pre) begin exps[6] = ok_len ? ACK : NACK; rq[6] = "R3"; end
    if (ok_pre && ok_len) begin exps[8] = ok_mode ? ACK : NACK; rq[8] = "R4"; end
    if (all_ok) begin exps[9 + n] = bad_sum ? NACK : ACK; rq[9 + n] = "R6"; end
    for (int i = 0; i < 16; i++) bmem[i] = 32'hDEAD_BEEF;
    wcount = 0;
    cs_n = 1'b0;
    waitc(H);
    check("R7", rel_pads, 0, "completion cleared by new select");
    len_sent = (stop_at >= 0) ? stop_at : total;
    for (int k = 0; k < len_sent; k++) begin
      xfer(txs[k], r);
      check(rq[k], r, exps[k], $sformatf("response slot %0d", k));
    end
    waitc(H);
    cs_n = 1'b1;
    waitc(H);
    check("R1", miso, 0, "miso low after deselect");
    full = all_ok && stop_at < 0;
    check(stop_at >= 0 ? "R8" : "R7", rel_pads, full, "rel_pads after session");
    check(stop_at >= 0 ? "R8" : "R7", sum_ok, full && !bad_sum, "sum_ok after session");
    if (!all_ok) exp_w = 0;
    else if (stop_at < 0) exp_w = nw;
    else exp_w = (stop_at > 8) ? (stop_at - 8) / 4 : 0;
    if (exp_w > nw) exp_w = nw;
    check(stop_at >= 0 ? "R8" : "R5", wcount, exp_w, "word writes");
    for (int i = 0; i < exp_w; i++)
      check("R5", bmem[i], {pl[4*i+3], pl[4*i+2], pl[4*i+1], pl[4*i]}, $sformatf("word %0d", i));
  endtask

  initial begin
    void'($urandom(32'd2024));
    waitc(4);
    // R9: reset state
    check("R9", miso, 0, "miso in reset");
    check("R9", wr_en, 0, "wr_en in reset");
    check("R9", rel_pads, 0, "rel_pads in reset");
    check("R9", sum_ok, 0, "sum_ok in reset");
    rst_n = 1'b1;
    waitc(4);
    check("R1", miso, 0, "miso idle");
    session(1, 8'h50, 8'h00, 0, -1, 2);    // R5 R6 R7 single word
    session(0, 8'h50, 8'h00, 0, -1, 1);    // R6 zero length
    session(16, 8'h50, 8'h00, 0, -1, 2);   // R3 largest accepted
    session(17, 8'h50, 8'h00, 0, -1, 0);   // R3 length too large
    session(2, 8'h51, 8'h00, 0, -1, 0);    // R2 wrong opening byte
    session(2, 8'h50, 8'h01, 0, -1, 0);    // R4 16-bit mode rejected
    session(2, 8'h50, 8'h02, 0, -1, 0);    // R4 32-bit mode rejected
    session(2, 8'h50, 8'h03, 0, -1, 0);    // R4 reserved mode rejected
    session(3, 8'h50, 8'h00, 1, -1, 2);    // R6 R7 checksum mismatch
    session(8, 8'h50, 8'h00, 0, 14, 0);    // R8 abort mid word
    session(4, 8'h50, 8'h00, 0, -1, 0);    // R8 recovery
    for (int i = 0; i < 6; i++) begin
      int nw;
      logic [7:0] md;
      nw = 1 + int'($urandom % 8);
      md = ($urandom % 4 == 0) ? 8'($urandom % 4) : 8'h00;
      session(nw, 8'h50, md, ($urandom % 3) == 0, -1, 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule